// File: doc/BRIEF.md
# USB Host Transaction Status Logger

This block condenses the result of one USB host transaction into a 16-bit status word for firmware to read. The serializer, CRC checkers, response timers and byte counter elsewhere in the host engine raise their indications at the end of a transaction. This block then resolves those indications against each other and latches the resulting word on a single transaction-done strobe. The word holds until the next transaction begins.

Outcomes are graded by a fixed priority: timeout first, then error, then STALL, then NAK, then ACK. The result is never more than one of these flags. The data-toggle bit is reported only for an acknowledged transaction. The length comparison is reported separately from the error flag. The block also holds the write-only token control register, which selects the PID and the endpoint for the next token.

Top module: `hts_txn_status_log`

## Requirements
- R1: On a cycle with `txn_done` high, the status word takes the new result, which is visible from the next clock edge. Bit positions: 0 ACK, 1 error, 2 timeout, 3 toggle, 5 length exception, 6 NAK, 7 STALL, 10 underflow, 11 overflow.
- R2: At most one of timeout, error, STALL, NAK and ACK is set. When several inputs apply, the winner is taken in this order: timeout, error, STALL, NAK, ACK.
- R3: Any of `crc5_err`, `crc16_err` or `pid_err` sets the error flag, unless a timeout is present.
- R4: For a non-isochronous transfer (`iso_xfer`=0), ACK is set only when `hs_class`=2'b01 (ACK) and no higher outcome applies. `hs_class`=2'b00 (no handshake) sets no outcome flag.
- R5: For an isochronous transfer, ACK is set when the transfer has no timeout, no error, no NAK and no STALL, including when no handshake was seen.
- R6: Bit 3 equals `rx_toggle` when ACK is set, and is 0 otherwise. In particular it is 0 on error.
- R7: When `rx_count` > `host_count`, bits 11 and 5 are set. When `rx_count` < `host_count`, bits 10 and 5 are set. When the counts are equal, none of the three is set. The length result never affects the error flag.
- R8: Status bits 4, 8, 9 and 12 to 15 always read as zero.
- R9: `txn_start` alone clears the status word on the next edge. When `txn_start` and `txn_done` are high together, the captured result wins. With neither strobe, the word holds.
- R10: A write with `ctl_we` loads `ctl_wdata[7:4]` onto `tok_pid` and `ctl_wdata[3:0]` onto `tok_ep`. Bits 15:8 are ignored. Without `ctl_we`, both outputs hold.
- R11: Asserting `rst_n` low clears the status word and both token fields to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | New transaction begins; clears status |
| txn_done | input | 1 | Transaction finished; capture result |
| hs_class | input | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| timeout | input | 1 | Device response or handshake too late |
| crc5_err | input | 1 | Token CRC5 failure |
| crc16_err | input | 1 | Data CRC16 failure |
| pid_err | input | 1 | Unexpected packet type |
| rx_toggle | input | 1 | Received data PID: 1 DATA1, 0 DATA0 |
| iso_xfer | input | 1 | Transfer is isochronous |
| rx_count | input | CNT_W | Bytes received in data stage |
| host_count | input | CNT_W | Programmed transfer length |
| ctl_we | input | 1 | Token control write strobe |
| ctl_wdata | input | 16 | Token control write data |
| status | output | 16 | Transaction status word |
| tok_pid | output | 4 | Selected token PID |
| tok_ep | output | 4 | Selected endpoint |

## Verification
Two functions can fall in the same cycle. The clear that a new transaction's start performs can meet the capture that a done strobe performs. Independently, a token-register write can coincide with a capture. The bench raises `txn_start` and `txn_done` together with a nonzero result and expects the captured word, not zero. In that same cycle it writes the token register and expects both the status and the token fields updated, neither disturbing the other.

// File: rtl/hts_pkg.sv
package hts_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int STAT_W    = 16;
  localparam int B_ACK     = 0;
  localparam int B_ERR     = 1;
  localparam int B_TMO     = 2;
  localparam int B_TOG     = 3;
  localparam int B_LEN     = 5;
  localparam int B_NAK     = 6;
  localparam int B_STALL   = 7;
  localparam int B_UNDER   = 10;
  localparam int B_OVER    = 11;

  localparam logic [STAT_W-1:0] LIVE_MASK =
    (16'h1 << B_ACK) | (16'h1 << B_ERR) | (16'h1 << B_TMO) |
    (16'h1 << B_TOG) | (16'h1 << B_LEN) | (16'h1 << B_NAK) |
    (16'h1 << B_STALL) | (16'h1 << B_UNDER) | (16'h1 << B_OVER);

  typedef struct packed {
    logic ack;
    logic err;
    logic tmo;
    logic nak;
    logic stall;
    logic tog;
  } outcome_t;
endpackage

// File: rtl/hts_rst_sync.sv
module hts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hts_outcome_resolve.sv
module hts_outcome_resolve
  import hts_pkg::*;
(
  input  hs_e      hs,
  input  logic     timeout,
  input  logic     crc5_err,
  input  logic     crc16_err,
  input  logic     pid_err,
  input  logic     rx_toggle,
  input  logic     iso_xfer,
  output outcome_t res
);
  logic any_err;
  logic ack_cond;

  assign any_err  = crc5_err | crc16_err | pid_err;
  assign ack_cond = iso_xfer ? (hs == HS_NONE || hs == HS_ACK) : (hs == HS_ACK);

  always_comb begin
    res = '0;
    if (timeout)              res.tmo   = 1'b1;
    else if (any_err)         res.err   = 1'b1;
    else if (hs == HS_STALL)  res.stall = 1'b1;
    else if (hs == HS_NAK)    res.nak   = 1'b1;
    else if (ack_cond)        res.ack   = 1'b1;
    res.tog = res.ack & rx_toggle;
  end
endmodule

// File: rtl/hts_len_cmp.sv
module hts_len_cmp #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] host_count,
  output logic             over,
  output logic             under,
  output logic             exc
);
  logic [CNT_W:0] diff;

  assign diff  = {1'b0, rx_count} - {1'b0, host_count};
  assign under = diff[CNT_W];
  assign over  = ~diff[CNT_W] & (|diff[CNT_W-1:0]);
  assign exc   = over | under;
endmodule

// File: rtl/hts_tok_reg.sv
module hts_tok_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [3:0]  pid,
  output logic [3:0]  ep
);
  logic [7:0] ctl_d, ctl_q;
  logic       unused_rsvd;

  assign unused_rsvd = ^wdata[15:8];

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= ctl_d;
  end

  assign pid = ctl_q[7:4];
  assign ep  = ctl_q[3:0];
endmodule

// File: rtl/hts_status_reg.sv
module hts_status_reg
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  outcome_t          res,
  input  logic              over,
  input  logic              under,
  input  logic              exc,
  output logic [STAT_W-1:0] word
);
  logic [STAT_W-1:0] raw, cap, st_d, st_q;
  logic              en;

  always_comb begin
    raw          = '0;
    raw[B_ACK]   = res.ack;
    raw[B_ERR]   = res.err;
    raw[B_TMO]   = res.tmo;
    raw[B_TOG]   = res.tog;
    raw[B_LEN]   = exc;
    raw[B_NAK]   = res.nak;
    raw[B_STALL] = res.stall;
    raw[B_UNDER] = under;
    raw[B_OVER]  = over;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_mask
    if (LIVE_MASK[i]) begin : g_live
      assign cap[i] = raw[i];
    end else begin : g_zero
      assign cap[i] = 1'b0;
    end
  end

  assign en = start | done;

  always_comb begin
    st_d = st_q;
    if (done)       st_d = cap;
    else if (start) st_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= '0;
    else if (en) st_q <= st_d;
  end

  assign word = st_q;
endmodule

// File: rtl/hts_txn_status_log.sv
module hts_txn_status_log
  import hts_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              txn_done,
  input  logic [1:0]        hs_class,
  input  logic              timeout,
  input  logic              crc5_err,
  input  logic              crc16_err,
  input  logic              pid_err,
  input  logic              rx_toggle,
  input  logic              iso_xfer,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  host_count,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       status,
  output logic [3:0]        tok_pid,
  output logic [3:0]        tok_ep
);
  logic     rst_n_int;
  outcome_t res;
  logic     over, under, exc;

  hts_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  hts_outcome_resolve u_res (
    .hs(hs_e'(hs_class)), .timeout(timeout), .crc5_err(crc5_err),
    .crc16_err(crc16_err), .pid_err(pid_err), .rx_toggle(rx_toggle),
    .iso_xfer(iso_xfer), .res(res)
  );

  hts_len_cmp #(.CNT_W(CNT_W)) u_len (
    .rx_count(rx_count), .host_count(host_count),
    .over(over), .under(under), .exc(exc)
  );

  hts_status_reg u_stat (
    .clk(clk), .rst_n(rst_n_int), .start(txn_start), .done(txn_done),
    .res(res), .over(over), .under(under), .exc(exc), .word(status)
  );

  hts_tok_reg u_tok (
    .clk(clk), .rst_n(rst_n_int), .we(ctl_we), .wdata(ctl_wdata),
    .pid(tok_pid), .ep(tok_ep)
  );
endmodule

// File: rtl/hts_txn_status_chk.sv
module hts_txn_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txn_start,
  input logic        txn_done,
  input logic        ctl_we,
  input logic [15:0] status,
  input logic [3:0]  tok_pid,
  input logic [3:0]  tok_ep
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[0], status[1], status[2], status[6], status[7]})); // R2
  AST_TOGGLE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[0]); // R6
  AST_LEN_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] == (status[10] | status[11])); // R7
  AST_NOT_BOTH_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[10] && status[11])); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 16'hF310) == 16'h0); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && !txn_done) |=> status == 16'h0); // R9
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_done) |=> $stable(status)); // R9
  AST_TOKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable(tok_pid) && $stable(tok_ep))); // R10
endmodule

bind hts_txn_status_log hts_txn_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_done(txn_done),
  .ctl_we(ctl_we), .status(status), .tok_pid(tok_pid), .tok_ep(tok_ep)
);

// File: tb/hts_txn_status_log_tb_top.sv
module hts_txn_status_log_tb_top;
  localparam int CW = 10;
  localparam int NV = 14;

  // {hs[1:0], tmo, c5, c16, pe, tog, iso, rx[9:0], hc[9:0], exp[15:0]}
  localparam logic [43:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd8,  10'd8, 16'h0009}, // R4 R6
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8,  10'd8, 16'h0001}, // R4
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd8,  10'd8, 16'h0040}, // R1 R6
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8,  10'd8, 16'h0080}, // R1
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8,  10'd8, 16'h0004}, // R2
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd8,  10'd8, 16'h0002}, // R3 R6
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd8,  10'd8, 16'h0002}, // R2 R3
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd8,  10'd8, 16'h0002}, // R3
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'd8,  10'd8, 16'h0009}, // R5
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'd8,  10'd8, 16'h0002}, // R5
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd12, 10'd8, 16'h0821}, // R7
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd3,  10'd8, 16'h0421}, // R7
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd8,  10'd8, 16'h0000}, // R4 R8
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0,  10'd4, 16'h04A0}  // R7
  };

  logic clk, rst_n;
  logic txn_start, txn_done, timeout, crc5_err, crc16_err, pid_err;
  logic rx_toggle, iso_xfer, ctl_we;
  logic [1:0] hs_class;
  logic [CW-1:0] rx_count, host_count;
  logic [15:0] ctl_wdata, status;
  logic [3:0] tok_pid, tok_ep;
  int n_run, n_fail;
  logic done_flag;

  hts_txn_status_log #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_done(txn_done),
    .hs_class(hs_class), .timeout(timeout), .crc5_err(crc5_err),
    .crc16_err(crc16_err), .pid_err(pid_err), .rx_toggle(rx_toggle),
    .iso_xfer(iso_xfer), .rx_count(rx_count), .host_count(host_count),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .status(status),
    .tok_pid(tok_pid), .tok_ep(tok_ep)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [43:0] v);
    {hs_class, timeout, crc5_err, crc16_err, pid_err, rx_toggle, iso_xfer,
     rx_count, host_count} = v[43:16];
  endtask

  task automatic run_txn(input logic [43:0] v);
    @(negedge clk); apply(v); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0; txn_done = 1'b1;
    @(negedge clk); txn_done = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done_flag = 1'b0;
    rst_n = 1'b0; txn_start = 1'b0; txn_done = 1'b0; ctl_we = 1'b0;
    ctl_wdata = '0; apply('0);
    repeat (3) @(negedge clk);
    check("R11 reset status", status, 16'h0);
    check("R11 reset token", {8'h0, tok_pid, tok_ep}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i]);
      check($sformatf("R1 vector %0d", i), status, VEC[i][15:0]);
    end

    // R9 hold over idle cycles
    run_txn(VEC[10]);
    repeat (5) @(negedge clk);
    check("R9 hold", status, 16'h0821);

    // R9 start alone clears
    txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
    check("R9 start clears", status, 16'h0);

    // R10 token write, reserved bits ignored
    ctl_we = 1'b1; ctl_wdata = 16'hFFA5;
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = 16'h1234;
    check("R10 token write", {8'h0, tok_pid, tok_ep}, 16'h00A5);
    repeat (2) @(negedge clk);
    check("R10 token hold", {8'h0, tok_pid, tok_ep}, 16'h00A5);

    // R9 start and done together, token write in same cycle
    apply(VEC[0]); txn_start = 1'b1; txn_done = 1'b1;
    ctl_we = 1'b1; ctl_wdata = 16'h003C;
    @(negedge clk); txn_start = 1'b0; txn_done = 1'b0; ctl_we = 1'b0;
    check("R9 done wins over start", status, 16'h0009);
    check("R10 write beside capture", {8'h0, tok_pid, tok_ep}, 16'h003C);

    // R11 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R11 async clear status", status, 16'h0);
    check("R11 async clear token", {8'h0, tok_pid, tok_ep}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule